// File: doc/BRIEF.md
# Full-Speed Preamble Transmit Sequencer

This block drives the transmit line of a full-speed link segment. It can also send a low-speed packet across that segment. Two transmit behaviours are selected by a 2-bit transceiver-select input, sampled when a packet starts.

In ordinary operation, each packet the link submits is sent at the full-speed bit rate. The block generates the SYNC, then sends the link's bytes, then the end-of-packet.

In preamble operation, the block first sends a full-speed preamble header of its own: a SYNC followed by the PRE PID. It then drives J for a short hold and releases the line for a gap. Only after that does it start the link's packet at the low-speed bit rate, with its own SYNC and end-of-packet.

Bit timing comes from two single-cycle strobes, one per full-speed bit and one per low-speed bit. All output is NRZI encoded with bit stuffing. The output is a line symbol (J, K or SE0) together with an output-enable.

The link presents bytes with a valid/ready/last handshake. Ready is raised only when the sequencer holds no byte and the last byte has not yet been taken. The link must present each following byte within one bit time of ready rising; if no byte is held when the next bit is due, the packet is closed.

Top module: `usb_pre_tx_seq`

## Requirements
- R1: When the transceiver-select input is 00b, 01b or 10b at packet start, the packet is sent at the full-speed rate with no header. The order is SYNC, then the bytes, then the end-of-packet, with one symbol per full-speed strobe.
- R2: When the transceiver-select input is 11b at packet start, the first 16 full-speed bit times carry the NRZI encoding of the SYNC byte 0x80 and then the PRE PID byte 0x3C, each sent least significant bit first. Encoding starts from J, so the first symbol is K.
- R3: In the full-speed bit times directly after the PRE PID, the line is driven to J with output-enable high for HOLD_FS_BITS bit times. After that the output-enable is low until the low-speed SYNC begins.
- R4: The low-speed SYNC begins on the first low-speed strobe at which at least GAP_FS_BITS full-speed strobes have occurred since the J hold began. GAP_FS_BITS must be at least 4.
- R5: In preamble operation, the SYNC and the link's bytes are sent least significant bit first. Each symbol is held for one low-speed strobe period. A 0 bit toggles the line between J and K; a 1 bit keeps it.
- R6: After six consecutive 1 bits, a stuffed 0 (one toggle) is inserted before the next bit. This also applies before the end-of-packet.
- R7: The packet ends with SE0 for EOP_SE0_BITS bit times of the packet rate, then J for one bit time with output-enable high. Output-enable then drops and the block returns to idle.
- R8: Ready is low in idle and throughout the header, the hold and the gap. It first rises in the cycle after the packet's SYNC starts. Exactly one byte is accepted per byte serialized, and none after the byte flagged last.
- R9: Line symbols are coded SE0 = 00b, J = 01b, K = 10b; 11b never appears. Whenever output-enable is low the symbol is J. After reset, output-enable and ready are low.
- R10: The line symbol and output-enable change only in the cycle following a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xcvr_sel | input | 2 | Transceiver select; 11b selects preamble operation |
| fs_bit_en | input | 1 | One-cycle strobe per full-speed bit time |
| ls_bit_en | input | 1 | One-cycle strobe per low-speed bit time |
| tx_data | input | DATA_W | Packet byte from the link |
| tx_valid | input | 1 | Byte valid |
| tx_last | input | 1 | Marks the final byte of the packet |
| tx_ready | output | 1 | Byte accepted when high together with tx_valid |
| line_sym | output | 2 | Line symbol: SE0 00b, J 01b, K 10b |
| line_oe | output | 1 | Output-enable for the line driver |

## Verification
The bench builds the block with GAP_FS_BITS = 6 and HOLD_FS_BITS = 2. A multi-bit hold and a gap that is not a multiple of the low-speed period make both windows visible in the sampled trace. The full-speed strobe comes every 2 cycles and the low-speed strobe every 16 cycles. In preamble mode, the packet start is swept across all sixteen cycle offsets of the low-speed period, which exercises every rounding of the gap to the next low-speed strobe. Byte patterns with long runs of ones drive stuffing inside the data and right before the end-of-packet. All four select codes are used.

// File: rtl/usb_pre_pkg.sv
package usb_pre_pkg;

   typedef enum logic [1:0] {
      SYM_SE0 = 2'b00,
      SYM_J   = 2'b01,
      SYM_K   = 2'b10
   } line_sym_t;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_BIT,
      CMD_STUFF,
      CMD_J,
      CMD_SE0,
      CMD_OFF
   } line_cmd_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_SPACE,
      ST_SYNC,
      ST_DATA,
      ST_EOP
   } seq_state_t;

   localparam int          HDR_LEN  = 16;
   localparam logic [7:0]  SYNC_PAT = 8'h80;
   localparam logic [7:0]  PRE_PID  = 8'h3C;
   localparam logic [15:0] HDR_BITS = {PRE_PID, SYNC_PAT};
   localparam logic [1:0]  SEL_PRE  = 2'b11;

endpackage

// File: rtl/usb_pre_line_enc.sv
module usb_pre_line_enc
   import usb_pre_pkg::*;
#(
   parameter int STUFF_RUN = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  line_cmd_t   cmd_i,
   input  logic        cmd_bit_i,
   output logic [1:0]  sym_o,
   output logic        oe_o,
   output logic        stuff_due_o
);

   localparam int ONES_W = $clog2(STUFF_RUN + 1);
   localparam logic [ONES_W-1:0] RUN_C = ONES_W'(STUFF_RUN);

   line_sym_t         sym_q;
   logic              oe_q;
   logic [ONES_W-1:0] ones_q;
   line_sym_t         toggled;

   assign toggled = (sym_q == SYM_J) ? SYM_K : SYM_J;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sym_q  <= SYM_J;
         oe_q   <= 1'b0;
         ones_q <= '0;
      end else begin
         case (cmd_i)
            CMD_BIT: begin
               oe_q <= 1'b1;
               if (cmd_bit_i) begin
                  ones_q <= ones_q + 1'b1;
               end else begin
                  sym_q  <= toggled;
                  ones_q <= '0;
               end
            end
            CMD_STUFF: begin
               oe_q   <= 1'b1;
               sym_q  <= toggled;
               ones_q <= '0;
            end
            CMD_J: begin
               oe_q   <= 1'b1;
               sym_q  <= SYM_J;
               ones_q <= '0;
            end
            CMD_SE0: begin
               oe_q   <= 1'b1;
               sym_q  <= SYM_SE0;
               ones_q <= '0;
            end
            CMD_OFF: begin
               oe_q   <= 1'b0;
               sym_q  <= SYM_J;
               ones_q <= '0;
            end
            default: ;
         endcase
      end
   end

   assign sym_o       = sym_q;
   assign oe_o        = oe_q;
   assign stuff_due_o = (ones_q == RUN_C);

endmodule

// File: rtl/usb_pre_byte_buf.sv
module usb_pre_byte_buf #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              open_i,
   input  logic              take_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   input  logic              last_i,
   output logic              ready_o,
   output logic              have_o,
   output logic              bit_o
);

   localparam int BIDX_W = $clog2(DATA_W);
   localparam logic [BIDX_W-1:0] BIDX_END = BIDX_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh_q;
   logic [BIDX_W-1:0] bidx_q;
   logic              have_q;
   logic              last_q;

   assign ready_o = open_i && !have_q && !last_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         sh_q   <= '0;
         bidx_q <= '0;
         have_q <= 1'b0;
         last_q <= 1'b0;
      end else begin
         if (valid_i && ready_o) begin
            sh_q   <= data_i;
            bidx_q <= '0;
            have_q <= 1'b1;
            last_q <= last_i;
         end
         if (take_i) begin
            if (bidx_q == BIDX_END) begin
               have_q <= 1'b0;
               bidx_q <= '0;
            end else begin
               bidx_q <= bidx_q + 1'b1;
            end
         end
      end
   end

   assign have_o = have_q;
   assign bit_o  = sh_q[bidx_q];

endmodule

// File: rtl/usb_pre_seq_ctrl.sv
module usb_pre_seq_ctrl
   import usb_pre_pkg::*;
#(
   parameter int GAP_FS_BITS  = 4,
   parameter int HOLD_FS_BITS = 1,
   parameter int EOP_SE0_BITS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_i,
   input  logic       fs_tick_i,
   input  logic       ls_tick_i,
   input  logic       start_req_i,
   input  logic       stuff_due_i,
   input  logic       have_byte_i,
   input  logic       byte_bit_i,
   output line_cmd_t  cmd_o,
   output logic       cmd_bit_o,
   output logic       open_o,
   output logic       take_o,
   output logic       clear_o
);

   localparam int CNT_W = $clog2(GAP_FS_BITS + EOP_SE0_BITS + 10);
   localparam int IDX_W = $clog2(HDR_LEN + 1);
   localparam logic [CNT_W:0]   GAP_C  = (CNT_W+1)'(GAP_FS_BITS);
   localparam logic [CNT_W:0]   HOLD_C = (CNT_W+1)'(HOLD_FS_BITS);
   localparam logic [CNT_W-1:0] EOP_C  = CNT_W'(EOP_SE0_BITS);
   localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_LEN);
   localparam logic [IDX_W-1:0] SYNC_END = IDX_W'(7);

   seq_state_t       state_q, state_d;
   logic             pre_q, pre_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             pkt_tick;
   logic [CNT_W:0]   elapsed;

   assign pkt_tick = pre_q ? ls_tick_i : fs_tick_i;
   assign elapsed  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, fs_tick_i};
   assign open_o   = (state_q == ST_SYNC) || (state_q == ST_DATA);

   always_comb begin
      state_d   = state_q;
      pre_d     = pre_q;
      idx_d     = idx_q;
      cnt_d     = cnt_q;
      cmd_o     = CMD_NONE;
      cmd_bit_o = 1'b0;
      take_o    = 1'b0;
      clear_o   = 1'b0;
      case (state_q)
         ST_IDLE: begin
            if (fs_tick_i && start_req_i) begin
               clear_o = 1'b1;
               cmd_o   = CMD_BIT;
               idx_d   = IDX_W'(1);
               if (mode_i == SEL_PRE) begin
                  pre_d     = 1'b1;
                  cmd_bit_o = HDR_BITS[0];
                  state_d   = ST_HDR;
               end else begin
                  pre_d     = 1'b0;
                  cmd_bit_o = SYNC_PAT[0];
                  state_d   = ST_SYNC;
               end
            end
         end
         ST_HDR: begin
            if (fs_tick_i) begin
               if (stuff_due_i) begin
                  cmd_o = CMD_STUFF;
               end else if (idx_q == HDR_END) begin
                  cmd_o   = CMD_J;
                  cnt_d   = '0;
                  state_d = ST_SPACE;
               end else begin
                  cmd_o     = CMD_BIT;
                  cmd_bit_o = HDR_BITS[idx_q[3:0]];
                  idx_d     = idx_q + 1'b1;
               end
            end
         end
         ST_SPACE: begin
            if (ls_tick_i && (elapsed >= GAP_C)) begin
               cmd_o     = CMD_BIT;
               cmd_bit_o = SYNC_PAT[0];
               idx_d     = IDX_W'(1);
               state_d   = ST_SYNC;
            end else if (fs_tick_i) begin
               cnt_d = (elapsed >= GAP_C) ? GAP_C[CNT_W-1:0] : elapsed[CNT_W-1:0];
               cmd_o = (elapsed < HOLD_C) ? CMD_J : CMD_OFF;
            end
         end
         ST_SYNC: begin
            if (pkt_tick) begin
               if (stuff_due_i) begin
                  cmd_o = CMD_STUFF;
               end else begin
                  cmd_o     = CMD_BIT;
                  cmd_bit_o = SYNC_PAT[idx_q[2:0]];
                  if (idx_q == SYNC_END) state_d = ST_DATA;
                  else                   idx_d   = idx_q + 1'b1;
               end
            end
         end
         ST_DATA: begin
            if (pkt_tick) begin
               if (stuff_due_i) begin
                  cmd_o = CMD_STUFF;
               end else if (have_byte_i) begin
                  cmd_o     = CMD_BIT;
                  cmd_bit_o = byte_bit_i;
                  take_o    = 1'b1;
               end else begin
                  cmd_o   = CMD_SE0;
                  cnt_d   = CNT_W'(1);
                  state_d = ST_EOP;
               end
            end
         end
         ST_EOP: begin
            if (pkt_tick) begin
               if (cnt_q < EOP_C) begin
                  cmd_o = CMD_SE0;
                  cnt_d = cnt_q + 1'b1;
               end else if (cnt_q == EOP_C) begin
                  cmd_o = CMD_J;
                  cnt_d = cnt_q + 1'b1;
               end else begin
                  cmd_o   = CMD_OFF;
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pre_q   <= 1'b0;
         idx_q   <= '0;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         pre_q   <= pre_d;
         idx_q   <= idx_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/usb_pre_tx_seq.sv
module usb_pre_tx_seq
   import usb_pre_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int GAP_FS_BITS  = 4,
   parameter int HOLD_FS_BITS = 1,
   parameter int EOP_SE0_BITS = 2,
   parameter int STUFF_RUN    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        xcvr_sel,
   input  logic              fs_bit_en,
   input  logic              ls_bit_en,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   input  logic              tx_last,
   output logic              tx_ready,
   output logic [1:0]        line_sym,
   output logic              line_oe
);

   if (GAP_FS_BITS < 4) begin : g_gap_bad
      $error("GAP_FS_BITS must be at least 4");
   end
   if (HOLD_FS_BITS < 1 || HOLD_FS_BITS >= GAP_FS_BITS) begin : g_hold_bad
      $error("HOLD_FS_BITS must be at least 1 and below GAP_FS_BITS");
   end
   if (EOP_SE0_BITS < 1) begin : g_eop_bad
      $error("EOP_SE0_BITS must be at least 1");
   end
   if (DATA_W < 2 || STUFF_RUN < 1) begin : g_width_bad
      $error("DATA_W must be at least 2 and STUFF_RUN at least 1");
   end

   line_cmd_t cmd;
   logic      cmd_bit;
   logic      stuff_due;
   logic      open_win;
   logic      take_bit;
   logic      clear_buf;
   logic      have_byte;
   logic      byte_bit;

   usb_pre_seq_ctrl #(
      .GAP_FS_BITS  (GAP_FS_BITS),
      .HOLD_FS_BITS (HOLD_FS_BITS),
      .EOP_SE0_BITS (EOP_SE0_BITS)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mode_i      (xcvr_sel),
      .fs_tick_i   (fs_bit_en),
      .ls_tick_i   (ls_bit_en),
      .start_req_i (tx_valid),
      .stuff_due_i (stuff_due),
      .have_byte_i (have_byte),
      .byte_bit_i  (byte_bit),
      .cmd_o       (cmd),
      .cmd_bit_o   (cmd_bit),
      .open_o      (open_win),
      .take_o      (take_bit),
      .clear_o     (clear_buf)
   );

   usb_pre_byte_buf #(
      .DATA_W (DATA_W)
   ) i_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear_buf),
      .open_i  (open_win),
      .take_i  (take_bit),
      .data_i  (tx_data),
      .valid_i (tx_valid),
      .last_i  (tx_last),
      .ready_o (tx_ready),
      .have_o  (have_byte),
      .bit_o   (byte_bit)
   );

   usb_pre_line_enc #(
      .STUFF_RUN (STUFF_RUN)
   ) i_enc (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_i       (cmd),
      .cmd_bit_i   (cmd_bit),
      .sym_o       (line_sym),
      .oe_o        (line_oe),
      .stuff_due_o (stuff_due)
   );

endmodule

// File: rtl/usb_pre_tx_seq_chk.sv
module usb_pre_tx_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       fs_bit_en,
   input logic       ls_bit_en,
   input logic       tx_ready,
   input logic [1:0] line_sym,
   input logic       line_oe
);

   p_sym_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      line_sym != 2'b11);

   p_released_j_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_oe |-> line_sym == 2'b01);

   p_ready_in_packet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> line_oe);

   p_first_sym_k_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_oe) |-> line_sym == 2'b10);

   p_change_on_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(fs_bit_en) && !$past(ls_bit_en)) |-> ($stable(line_sym) && $stable(line_oe)));

   p_eop_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
      line_sym == 2'b00 |-> line_oe);

endmodule

bind usb_pre_tx_seq usb_pre_tx_seq_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fs_bit_en (fs_bit_en),
   .ls_bit_en (ls_bit_en),
   .tx_ready  (tx_ready),
   .line_sym  (line_sym),
   .line_oe   (line_oe)
);

// File: tb/test_usb_pre_tx_seq.sv
`timescale 1ns/1ps
module test_usb_pre_tx_seq;

   localparam int FS_DIV = 2;
   localparam int LS_DIV = 16;
   localparam int GAP    = 6;
   localparam int HOLD   = 2;
   localparam int EOPN   = 2;
   localparam logic [1:0] S_SE0 = 2'b00;
   localparam logic [1:0] S_J   = 2'b01;
   localparam logic [1:0] S_K   = 2'b10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] xcvr_sel = 2'b00;
   logic       fs_bit_en = 1'b0;
   logic       ls_bit_en = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_last = 1'b0;
   logic       tx_ready;
   logic [1:0] line_sym;
   logic       line_oe;

   always #2.5 clk = ~clk;

   usb_pre_tx_seq #(
      .DATA_W (8), .GAP_FS_BITS (GAP), .HOLD_FS_BITS (HOLD),
      .EOP_SE0_BITS (EOPN), .STUFF_RUN (6)
   ) i_usb_pre_tx_seq (
      .clk (clk), .rst_n (rst_n), .xcvr_sel (xcvr_sel),
      .fs_bit_en (fs_bit_en), .ls_bit_en (ls_bit_en),
      .tx_data (tx_data), .tx_valid (tx_valid), .tx_last (tx_last),
      .tx_ready (tx_ready), .line_sym (line_sym), .line_oe (line_oe)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [2:0] trace [0:32767];
   logic [2:0] expv  [0:4095];
   int         exp_len;
   int         gcount = 0;
   int         cyc = 0;
   bit         rdy_seen = 0;
   int         rdy_g = 0;
   int         stable_bad = 0;
   logic [2:0] prev_smp = 3'b001;
   logic [7:0] pkt [0:7];
   int         pkt_n;

   task automatic chk(input bit ok, input string req, input int act, input int expd);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
      end
   endtask

   // strobe generation and sampling, away from the active edge
   always @(negedge clk) begin
      if (fs_bit_en) begin
         trace[gcount] = {line_oe, line_sym};
         if (tx_ready && !rdy_seen) begin
            rdy_seen = 1;
            rdy_g    = gcount;
         end
         gcount++;
      end else if ({line_oe, line_sym} != prev_smp && rst_n) begin
         stable_bad++;
      end
      prev_smp  = {line_oe, line_sym};
      fs_bit_en = (cyc % FS_DIV == 0);
      ls_bit_en = (cyc % LS_DIV == 0);
      cyc++;
   end

   // expected-trace construction
   logic [1:0] lvl;
   int         ones;

   task automatic put(input logic [2:0] v, input int units);
      for (int i = 0; i < units; i++) begin
         expv[exp_len] = v;
         exp_len++;
      end
   endtask

   task automatic emit_bit(input logic b, input int unit);
      if (!b) begin
         lvl  = (lvl == S_J) ? S_K : S_J;
         ones = 0;
      end else begin
         ones++;
      end
      put({1'b1, lvl}, unit);
      if (ones == 6) begin
         lvl  = (lvl == S_J) ? S_K : S_J;
         ones = 0;
         put({1'b1, lvl}, unit);
      end
   endtask

   task automatic load(input int sel);
      case (sel % 4)
         0: begin pkt_n = 1; pkt[0] = 8'h5A; end
         1: begin pkt_n = 3; pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'h00; end
         2: begin pkt_n = 4; pkt[0] = 8'h3C; pkt[1] = 8'hC3; pkt[2] = 8'h7F; pkt[3] = 8'hFE; end
         default: begin pkt_n = 2; pkt[0] = 8'h80; pkt[1] = 8'hFF; end
      endcase
   endtask

   task automatic run_pkt(input logic [1:0] mode, input int delay);
      int  t0, s_start, unit, acc, idx;
      bit  pre, saw_se0, done, ok;
      int  bad_k;
      logic [15:0] hdr;
      pre = (mode == 2'b11);
      xcvr_sel = mode;
      repeat (delay) @(negedge clk);
      @(negedge clk); #1;
      t0 = gcount;
      rdy_seen = 0;
      acc = 0; idx = 0; saw_se0 = 0; done = 0;
      tx_valid = 1; tx_data = pkt[0]; tx_last = (pkt_n == 1);
      while (!done) begin
         @(negedge clk); #1;
         if (line_oe && line_sym == S_SE0) saw_se0 = 1;
         if (saw_se0 && !line_oe) begin
            done = 1;
         end else if (tx_ready && tx_valid) begin
            @(posedge clk); #1;
            acc++; idx++;
            if (idx < pkt_n) begin
               tx_data = pkt[idx]; tx_last = (idx == pkt_n - 1);
            end else begin
               tx_data = 8'hA5; tx_last = 0;
            end
         end
      end
      tx_valid = 0; tx_last = 0;

      // build expected trace, one entry per full-speed strobe
      exp_len = 0; lvl = S_J; ones = 0;
      hdr = 16'h3C80;
      s_start = t0;
      if (pre) begin
         for (int i = 0; i < 16; i++) emit_bit(hdr[i], 1);
         s_start = t0 + 16 + GAP;
         while (s_start % (LS_DIV / FS_DIV) != 0) s_start++;
         put({1'b1, S_J}, HOLD);
         put({1'b0, S_J}, s_start - (t0 + 16) - HOLD);
         lvl = S_J; ones = 0;
      end
      unit = pre ? (LS_DIV / FS_DIV) : 1;
      for (int i = 0; i < 8; i++) emit_bit(i == 7, unit);
      for (int b = 0; b < pkt_n; b++)
         for (int i = 0; i < 8; i++) emit_bit(pkt[b][i], unit);
      put({1'b1, S_SE0}, EOPN * unit);
      put({1'b1, S_J}, unit);
      put({1'b0, S_J}, 1);

      ok = 1; bad_k = 0;
      for (int k = 0; k < exp_len; k++) begin
         if (ok && trace[t0 + k] !== expv[k]) begin
            ok = 0; bad_k = k;
         end
      end
      if (pre)
         chk(ok, $sformatf("R2 R3 R4 R5 R6 R7 trace sym at unit %0d", bad_k),
             int'(trace[t0 + bad_k]), int'(expv[bad_k]));
      else
         chk(ok, $sformatf("R1 R6 R7 trace sym at unit %0d", bad_k),
             int'(trace[t0 + bad_k]), int'(expv[bad_k]));
      chk(rdy_seen && rdy_g == s_start, "R8 first ready strobe index", rdy_g - t0, s_start - t0);
      chk(acc == pkt_n, "R8 bytes accepted", acc, pkt_n);
   endtask

   initial begin
      repeat (10) @(negedge clk);
      rst_n = 1;
      @(negedge clk); #1;
      chk(line_oe == 0, "R9 reset oe", int'(line_oe), 0);
      chk(line_sym == S_J, "R9 reset symbol J", int'(line_sym), int'(S_J));
      chk(tx_ready == 0, "R8 reset ready", int'(tx_ready), 0);
      for (int m = 0; m < 3; m++)
         for (int p = 0; p < 4; p++) begin
            load(p);
            run_pkt(2'(m), p);
         end
      for (int ph = 0; ph < 16; ph++) begin
         load(ph);
         run_pkt(2'b11, ph);
      end
      chk(stable_bad == 0, "R10 output change without strobe", stable_bad, 0);
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(0, "watchdog expired", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule